// File: doc/BRIEF.md
# Four-Level Prioritised Interrupt Controller

This block arbitrates seven interrupt sources for an 8-bit microcontroller core. The sources are two external pins, three timers, a serial port and an I2C unit. Each source has an enable bit, and a global enable gates all of them. Two priority registers together give every source a 2-bit preemption level. The block samples the requests on every cycle and picks a winner: the highest level first, then a fixed polling order within that level. It then offers the winner's vector address to the core on a valid/ready channel.

The core takes an offer by raising `irq_ready` while `irq_valid` is high. The handshake is called "fire", and it marks the offered level as in service. Fire also clears the source flag if that flag is one hardware clears. Once the offer is up, its vector holds stable until the core takes it, so the core may apply back-pressure for as long as it needs. The block does not drop or replace an offer that is waiting. After each fire, `irq_valid` is low for at least one cycle. A one-cycle `reti` pulse ends the handler at the highest level in service, and any interrupted lower level then resumes.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset `irq_valid` is 0 and the enable and both priority registers read 0.
- R2: The register port holds an enable register at 0xA8, a low-priority register at 0xB8 and a high-priority register at 0xB7. Writes and reads of any other address have no effect and read 0. Bit 7 of each priority register reads 0. Bit positions in all three registers are: bit 7 global enable (enable register only), bit 6 I2C, bit 5 timer 2, bit 4 serial, bit 3 timer 1, bit 2 external 1, bit 1 timer 0, bit 0 external 0.
- R3: A source's level is {high-priority bit, low-priority bit}, from 0 (lowest) to 3 (highest). The pending request with the highest level wins, whatever its polling position.
- R4: Among pending requests of equal level, the winner is the first in this order: external 0, I2C, timer 0, external 1, timer 1, serial, timer 2.
- R5: The offered vectors are 0x03 for external 0, 0x0B for timer 0, 0x13 for external 1, 0x1B for timer 1, 0x23 for serial, 0x2B for I2C and 0x3B for timer 2.
- R6: No request is offered while the global enable bit is 0, nor from a source whose own enable bit is 0.
- R7: Once `irq_valid` rises, it stays high with `irq_vector` unchanged until a cycle in which `irq_ready` is high. In the cycle after that fire, `irq_valid` is 0.
- R8: A request is offered only if its level is strictly above every level in service. Fire marks the offered level as in service, so an equal-level request waits and a strictly higher one preempts.
- R9: A `reti` pulse removes the highest level in service, after which lower-level pending requests may be offered.
- R10: The external inputs are active low. In edge mode, a falling edge sets a flag that fire clears. In level mode, the request follows the pin and fire does not clear it.
- R11: A one-cycle overflow pulse on timer 0 or timer 1 sets a flag that fire clears. The serial request (RI or TI), the I2C request and the timer 2 request (TF2 or EXF2) follow their inputs, and fire does not clear them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sfr_wr | input | 1 | Register write strobe |
| sfr_addr | input | 8 | Register address for read and write |
| sfr_wdata | input | 8 | Register write data |
| sfr_rdata | output | 8 | Register read data for `sfr_addr` |
| ext0_n | input | 1 | External interrupt 0, active low |
| ext1_n | input | 1 | External interrupt 1, active low |
| ext0_edge | input | 1 | 1 selects edge mode for external 0 |
| ext1_edge | input | 1 | 1 selects edge mode for external 1 |
| tmr0_ovf | input | 1 | Timer 0 overflow pulse |
| tmr1_ovf | input | 1 | Timer 1 overflow pulse |
| tmr2_tf | input | 1 | Timer 2 overflow flag |
| tmr2_exf | input | 1 | Timer 2 external flag |
| ser_ri | input | 1 | Serial receive flag |
| ser_ti | input | 1 | Serial transmit flag |
| i2c_irq | input | 1 | I2C unit request |
| irq_valid | output | 1 | An interrupt is offered to the core |
| irq_ready | input | 1 | Core takes the offered interrupt |
| irq_vector | output | 8 | Vector address of the offer |
| reti | input | 1 | One-cycle return-from-interrupt pulse |

## Verification
The assertions assume `irq_ready` and `reti` are never high in the same cycle. They also assume `reti` arrives only while some level is in service, as a real core's handler nesting guarantees. The stimulus raises `irq_ready` only for one cycle while an offer is visible, and pulses `reti` only once per taken interrupt. All inputs change half a cycle away from the sampling edge. Timer overflow inputs are always single-cycle pulses.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int NSRC = 7;
  localparam int LVLW = 2;
  localparam int NLVL = 1 << LVLW;
  localparam int IDXW = $clog2(NSRC);

  // Source indices in polling order (index 0 is polled first).
  localparam int SI_EXT0 = 0;
  localparam int SI_I2C  = 1;
  localparam int SI_TMR0 = 2;
  localparam int SI_EXT1 = 3;
  localparam int SI_TMR1 = 4;
  localparam int SI_SER  = 5;
  localparam int SI_TMR2 = 6;

  typedef logic [LVLW-1:0] lvl_t;

  // Bit position of a source inside the enable and priority registers.
  function automatic logic [2:0] reg_bit(input int s);
    case (s)
      SI_EXT0: reg_bit = 3'd0;
      SI_TMR0: reg_bit = 3'd1;
      SI_EXT1: reg_bit = 3'd2;
      SI_TMR1: reg_bit = 3'd3;
      SI_SER:  reg_bit = 3'd4;
      SI_TMR2: reg_bit = 3'd5;
      default: reg_bit = 3'd6;
    endcase
  endfunction

  // Vector address: 8-byte slots starting at offset 3.
  function automatic logic [7:0] vec_of(input int s);
    logic [4:0] slot;
    case (s)
      SI_EXT0: slot = 5'd0;
      SI_TMR0: slot = 5'd1;
      SI_EXT1: slot = 5'd2;
      SI_TMR1: slot = 5'd3;
      SI_SER:  slot = 5'd4;
      SI_I2C:  slot = 5'd5;
      default: slot = 5'd7;
    endcase
    vec_of = {slot, 3'b011};
  endfunction
endpackage

// File: rtl/irq_regs.sv
module irq_regs
  import irq_pkg::*;
#(
  parameter logic [7:0] EN_ADDR  = 8'hA8,
  parameter logic [7:0] PLO_ADDR = 8'hB8,
  parameter logic [7:0] PHI_ADDR = 8'hB7
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr,
  input  logic [7:0]                 addr,
  input  logic [7:0]                 wdata,
  output logic [7:0]                 rdata,
  output logic                       glb_en,
  output logic [NSRC-1:0]            src_en,
  output logic [NSRC-1:0][LVLW-1:0]  src_lvl
);
  logic [7:0] en_q;
  logic [6:0] plo_q;
  logic [6:0] phi_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q  <= '0;
      plo_q <= '0;
      phi_q <= '0;
    end else if (wr) begin
      if (addr == EN_ADDR)  en_q  <= wdata;
      if (addr == PLO_ADDR) plo_q <= wdata[6:0];
      if (addr == PHI_ADDR) phi_q <= wdata[6:0];
    end
  end

  always_comb begin
    if (addr == EN_ADDR)       rdata = en_q;
    else if (addr == PLO_ADDR) rdata = {1'b0, plo_q};
    else if (addr == PHI_ADDR) rdata = {1'b0, phi_q};
    else                       rdata = '0;
  end

  assign glb_en = en_q[7];

  always_comb begin
    for (int s = 0; s < NSRC; s++) begin
      src_en[s]  = en_q[reg_bit(s)];
      src_lvl[s] = {phi_q[reg_bit(s)], plo_q[reg_bit(s)]};
    end
  end
endmodule

// File: rtl/irq_sources.sv
module irq_sources
  import irq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [1:0]      ext_n,
  input  logic [1:0]      ext_edge,
  input  logic [1:0]      tmr_ovf,
  input  logic            ser_ri,
  input  logic            ser_ti,
  input  logic            i2c_irq,
  input  logic            tmr2_tf,
  input  logic            tmr2_exf,
  input  logic [NSRC-1:0] clr,
  output logic [NSRC-1:0] req
);
  wire [1:0] ext_req;
  wire [1:0] tmr_req;
  logic ser_q, i2c_q, t2_q;

  for (genvar g = 0; g < 2; g++) begin : g_ext
    localparam int XI = (g == 0) ? SI_EXT0 : SI_EXT1;
    logic prev_q, flag_q, lvl_q;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        prev_q <= 1'b1;
        flag_q <= 1'b0;
        lvl_q  <= 1'b0;
      end else begin
        prev_q <= ext_n[g];
        lvl_q  <= ~ext_n[g];
        flag_q <= (prev_q & ~ext_n[g]) | (flag_q & ~clr[XI]);
      end
    end
    assign ext_req[g] = ext_edge[g] ? flag_q : lvl_q;
  end

  for (genvar g = 0; g < 2; g++) begin : g_tmr
    localparam int TI = (g == 0) ? SI_TMR0 : SI_TMR1;
    logic flag_q;
    always_ff @(posedge clk) begin
      if (!rst_n) flag_q <= 1'b0;
      else        flag_q <= tmr_ovf[g] | (flag_q & ~clr[TI]);
    end
    assign tmr_req[g] = flag_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ser_q <= 1'b0;
      i2c_q <= 1'b0;
      t2_q  <= 1'b0;
    end else begin
      ser_q <= ser_ri | ser_ti;
      i2c_q <= i2c_irq;
      t2_q  <= tmr2_tf | tmr2_exf;
    end
  end

  always_comb begin
    req          = '0;
    req[SI_EXT0] = ext_req[0];
    req[SI_EXT1] = ext_req[1];
    req[SI_TMR0] = tmr_req[0];
    req[SI_TMR1] = tmr_req[1];
    req[SI_SER]  = ser_q;
    req[SI_I2C]  = i2c_q;
    req[SI_TMR2] = t2_q;
  end
endmodule

// File: rtl/irq_pick.sv
module irq_pick
  import irq_pkg::*;
(
  input  logic [NSRC-1:0]           req,
  input  logic [NSRC-1:0]           src_en,
  input  logic                      glb_en,
  input  logic [NSRC-1:0][LVLW-1:0] src_lvl,
  input  logic [NLVL-1:0]           busy,
  output logic                      ok,
  output logic [IDXW-1:0]           idx,
  output lvl_t                      lvl
);
  logic [NSRC-1:0] elig;
  logic            found;

  assign elig = req & src_en & {NSRC{glb_en}};

  // Later matches overwrite earlier ones: inner loop runs downward so the
  // first polled source wins a level, outer loop upward so the top level wins.
  always_comb begin
    found = 1'b0;
    idx   = '0;
    lvl   = '0;
    for (int l = 0; l < NLVL; l++) begin
      for (int s = NSRC - 1; s >= 0; s--) begin
        if (elig[s] && (src_lvl[s] == lvl_t'(l))) begin
          found = 1'b1;
          idx   = IDXW'(s);
          lvl   = lvl_t'(l);
        end
      end
    end
    ok = found && ((busy >> lvl) == '0);
  end
endmodule

// File: rtl/irq_stack.sv
module irq_stack
  import irq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            fire,
  input  lvl_t            fire_lvl,
  input  logic            reti,
  output logic [NLVL-1:0] busy
);
  logic [NLVL-1:0] top;

  always_comb begin
    top = '0;
    for (int l = 0; l < NLVL; l++) begin
      if (busy[l]) top = NLVL'(1) << l;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= '0;
    end else begin
      busy <= (busy & ~(reti ? top : '0))
            | (fire ? (NLVL'(1) << fire_lvl) : '0);
    end
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import irq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sfr_wr,
  input  logic [7:0] sfr_addr,
  input  logic [7:0] sfr_wdata,
  output logic [7:0] sfr_rdata,
  input  logic       ext0_n,
  input  logic       ext1_n,
  input  logic       ext0_edge,
  input  logic       ext1_edge,
  input  logic       tmr0_ovf,
  input  logic       tmr1_ovf,
  input  logic       tmr2_tf,
  input  logic       tmr2_exf,
  input  logic       ser_ri,
  input  logic       ser_ti,
  input  logic       i2c_irq,
  output logic       irq_valid,
  input  logic       irq_ready,
  output logic [7:0] irq_vector,
  input  logic       reti
);
  logic                      glb_en;
  logic [NSRC-1:0]           src_en;
  logic [NSRC-1:0][LVLW-1:0] src_lvl;
  logic [NSRC-1:0]           req;
  logic [NSRC-1:0]           clr;
  logic [NLVL-1:0]           lvl_busy;
  logic                      win_ok;
  logic [IDXW-1:0]           win_idx;
  lvl_t                      win_lvl;

  logic                      valid_q;
  logic [IDXW-1:0]           idx_q;
  lvl_t                      lvl_q;
  logic [7:0]                vec_q;
  logic                      fire;

  irq_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr(sfr_wr), .addr(sfr_addr),
    .wdata(sfr_wdata), .rdata(sfr_rdata),
    .glb_en(glb_en), .src_en(src_en), .src_lvl(src_lvl)
  );

  irq_sources u_src (
    .clk(clk), .rst_n(rst_n),
    .ext_n({ext1_n, ext0_n}), .ext_edge({ext1_edge, ext0_edge}),
    .tmr_ovf({tmr1_ovf, tmr0_ovf}),
    .ser_ri(ser_ri), .ser_ti(ser_ti), .i2c_irq(i2c_irq),
    .tmr2_tf(tmr2_tf), .tmr2_exf(tmr2_exf),
    .clr(clr), .req(req)
  );

  irq_pick u_pick (
    .req(req), .src_en(src_en), .glb_en(glb_en), .src_lvl(src_lvl),
    .busy(lvl_busy), .ok(win_ok), .idx(win_idx), .lvl(win_lvl)
  );

  irq_stack u_stack (
    .clk(clk), .rst_n(rst_n), .fire(fire), .fire_lvl(lvl_q),
    .reti(reti), .busy(lvl_busy)
  );

  assign fire = valid_q & irq_ready;
  assign clr  = fire ? (NSRC'(1) << idx_q) : '0;

  // Offer register: captured only while idle, held until the core takes it.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      idx_q   <= '0;
      lvl_q   <= '0;
      vec_q   <= '0;
    end else if (fire) begin
      valid_q <= 1'b0;
    end else if (!valid_q) begin
      valid_q <= win_ok;
      idx_q   <= win_idx;
      lvl_q   <= win_lvl;
      vec_q   <= vec_of(int'(win_idx));
    end
  end

  assign irq_valid  = valid_q;
  assign irq_vector = vec_q;
endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       irq_valid,
  input logic       irq_ready,
  input logic [7:0] irq_vector,
  input logic       glb_en,
  input logic [3:0] busy
);
  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid && !irq_ready) |=> (irq_valid && $stable(irq_vector)));

  assert_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid && irq_ready) |=> !irq_valid);

  assert_vector_R5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> (irq_vector == 8'h03 || irq_vector == 8'h0B ||
                   irq_vector == 8'h13 || irq_vector == 8'h1B ||
                   irq_vector == 8'h23 || irq_vector == 8'h2B ||
                   irq_vector == 8'h3B));

  assert_mask_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!glb_en && !irq_valid) |=> !irq_valid);

  assert_top_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy[3] && !irq_valid) |=> !irq_valid);

  assert_fire_marks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid && irq_ready) |=> (busy != 4'b0000));
endmodule

bind prio_irq_ctrl irq_ctrl_chk chk_i (
  .clk(clk), .rst_n(rst_n), .irq_valid(irq_valid), .irq_ready(irq_ready),
  .irq_vector(irq_vector), .glb_en(glb_en), .busy(lvl_busy)
);

// File: tb/prio_irq_ctrl_tb_top.sv
module prio_irq_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       sfr_wr;
  logic [7:0] sfr_addr, sfr_wdata, sfr_rdata;
  logic       ext0_n, ext1_n, ext0_edge, ext1_edge;
  logic       tmr0_ovf, tmr1_ovf, tmr2_tf, tmr2_exf;
  logic       ser_ri, ser_ti, i2c_irq;
  logic       irq_valid, irq_ready, reti;
  logic [7:0] irq_vector;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  prio_irq_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .sfr_wr(sfr_wr), .sfr_addr(sfr_addr),
    .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata),
    .ext0_n(ext0_n), .ext1_n(ext1_n), .ext0_edge(ext0_edge), .ext1_edge(ext1_edge),
    .tmr0_ovf(tmr0_ovf), .tmr1_ovf(tmr1_ovf), .tmr2_tf(tmr2_tf), .tmr2_exf(tmr2_exf),
    .ser_ri(ser_ri), .ser_ti(ser_ti), .i2c_irq(i2c_irq),
    .irq_valid(irq_valid), .irq_ready(irq_ready), .irq_vector(irq_vector), .reti(reti)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=0x%0h exp=0x%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    #800000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired act=0x0 exp=0x1");
    summary();
    $finish;
  end

  task automatic do_reset();
    rst_n = 1'b0; sfr_wr = 1'b0; sfr_addr = 8'h00; sfr_wdata = 8'h00;
    ext0_n = 1'b1; ext1_n = 1'b1; ext0_edge = 1'b0; ext1_edge = 1'b0;
    tmr0_ovf = 1'b0; tmr1_ovf = 1'b0; tmr2_tf = 1'b0; tmr2_exf = 1'b0;
    ser_ri = 1'b0; ser_ti = 1'b0; i2c_irq = 1'b0; irq_ready = 1'b0; reti = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    sfr_wr = 1'b1; sfr_addr = a; sfr_wdata = d;
    @(negedge clk);
    sfr_wr = 1'b0;
  endtask

  task automatic rd_chk(input logic [7:0] a, input logic [7:0] exp, input string tag);
    sfr_addr = a;
    #1;
    chk(sfr_rdata == exp, tag, sfr_rdata, exp);
  endtask

  task automatic expect_vec(input logic [7:0] exp, input string tag);
    bit got = 1'b0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (irq_valid) begin
        got = 1'b1;
        break;
      end
    end
    chk(got && irq_vector == exp, tag, got ? irq_vector : 32'hFFFF, exp);
  endtask

  task automatic expect_quiet(input int n, input string tag);
    bit seen = 1'b0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (irq_valid) seen = 1'b1;
    end
    chk(!seen, tag, seen, 0);
  endtask

  task automatic ack();
    irq_ready = 1'b1;
    @(negedge clk);
    irq_ready = 1'b0;
  endtask

  task automatic ret();
    @(negedge clk);
    reti = 1'b1;
    @(negedge clk);
    reti = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    chk(irq_valid == 1'b0, "R1 valid after reset", irq_valid, 0);
    rd_chk(8'hA8, 8'h00, "R1 enable reg after reset");
    rd_chk(8'hB8, 8'h00, "R1 low prio after reset");
    rd_chk(8'hB7, 8'h00, "R1 high prio after reset");
  endtask

  task automatic t_regs();
    do_reset();
    wr(8'hA8, 8'hFF);
    wr(8'hB8, 8'hFF);
    wr(8'hB7, 8'h55);
    wr(8'h90, 8'hAA);
    rd_chk(8'hA8, 8'hFF, "R2 enable readback");
    rd_chk(8'hB8, 8'h7F, "R2 low prio bit7 reads 0");
    rd_chk(8'hB7, 8'h55, "R2 high prio readback");
    rd_chk(8'h90, 8'h00, "R2 unmapped reads 0");
  endtask

  task automatic t_vectors();
    do_reset();
    wr(8'hA8, 8'hFF);
    ext0_n = 1'b0; expect_vec(8'h03, "R5 ext0 vector"); ack(); ext0_n = 1'b1; ret();
    ext1_n = 1'b0; expect_vec(8'h13, "R5 ext1 vector"); ack(); ext1_n = 1'b1; ret();
    tmr0_ovf = 1'b1; @(negedge clk); tmr0_ovf = 1'b0;
    expect_vec(8'h0B, "R5 timer0 vector"); ack(); ret();
    tmr1_ovf = 1'b1; @(negedge clk); tmr1_ovf = 1'b0;
    expect_vec(8'h1B, "R5 timer1 vector"); ack(); ret();
    ser_ti = 1'b1; expect_vec(8'h23, "R5 serial TI vector"); ack(); ser_ti = 1'b0; ret();
    i2c_irq = 1'b1; expect_vec(8'h2B, "R5 I2C vector"); ack(); i2c_irq = 1'b0; ret();
    tmr2_exf = 1'b1; expect_vec(8'h3B, "R5 timer2 EXF vector"); ack(); tmr2_exf = 1'b0; ret();
    expect_quiet(6, "R11 timer flags cleared after fire");
  endtask

  task automatic t_mask();
    do_reset();
    wr(8'hA8, 8'h7F);
    ser_ri = 1'b1;
    expect_quiet(8, "R6 global enable off");
    wr(8'hA8, 8'hEF);
    expect_quiet(8, "R6 serial enable off");
    wr(8'hA8, 8'h90);
    expect_vec(8'h23, "R6 serial enabled");
  endtask

  task automatic t_poll();
    do_reset();
    wr(8'hA8, 8'hFF);
    ser_ri = 1'b1; ser_ti = 1'b1; i2c_irq = 1'b1; tmr2_tf = 1'b1; ext1_n = 1'b0;
    tmr1_ovf = 1'b1; @(negedge clk); tmr1_ovf = 1'b0;
    expect_vec(8'h2B, "R4 I2C first of equal level");
    ack();
    expect_quiet(6, "R8 equal level waits");
    i2c_irq = 1'b0; ret();
    expect_vec(8'h13, "R4 ext1 next");
    ack(); ext1_n = 1'b1; ret();
    expect_vec(8'h1B, "R4 timer1 next");
    ack(); ret();
    expect_vec(8'h23, "R4 serial next");
    ack(); ser_ri = 1'b0; ser_ti = 1'b0; ret();
    expect_vec(8'h3B, "R4 timer2 last");
    ack(); tmr2_tf = 1'b0; ret();
    expect_quiet(6, "R11 timer1 flag cleared");
  endtask

  task automatic t_levels();
    do_reset();
    wr(8'hA8, 8'hFF);
    wr(8'hB8, 8'h14);
    wr(8'hB7, 8'h24);
    ext0_n = 1'b0; ser_ri = 1'b1; tmr2_tf = 1'b1;
    expect_vec(8'h3B, "R3 level 2 beats earlier polled");
    ack();
    expect_quiet(6, "R8 lower level blocked");
    ext1_edge = 1'b1;
    ext1_n = 1'b0; @(negedge clk); ext1_n = 1'b1;
    expect_vec(8'h13, "R8 level 3 preempts");
    ack(); ret();
    expect_quiet(6, "R9 level 2 still in service");
    tmr2_tf = 1'b0; ret();
    expect_vec(8'h23, "R9 level 1 resumes");
    ack(); ser_ri = 1'b0; ret();
    expect_vec(8'h03, "R9 level 0 resumes");
    ack(); ext0_n = 1'b1; ret();
    expect_quiet(6, "R10 ext1 edge flag cleared");
  endtask

  task automatic t_ext_modes();
    do_reset();
    wr(8'hA8, 8'hFF);
    ext1_edge = 1'b1;
    ext1_n = 1'b0; @(negedge clk); ext1_n = 1'b1;
    expect_vec(8'h13, "R10 edge sets flag");
    ack(); ret();
    expect_quiet(6, "R10 edge flag cleared by fire");
    ext0_n = 1'b0;
    expect_vec(8'h03, "R10 level request");
    ack(); ret();
    expect_vec(8'h03, "R10 level not cleared by fire");
    ack(); ext0_n = 1'b1; ret();
    expect_quiet(6, "R10 level follows pin");
  endtask

  task automatic t_hold();
    bit stable = 1'b1;
    do_reset();
    wr(8'hA8, 8'hFF);
    i2c_irq = 1'b1;
    expect_vec(8'h2B, "R7 offer up");
    ext0_n = 1'b0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (!irq_valid || irq_vector != 8'h2B) stable = 1'b0;
    end
    chk(stable, "R7 held stable under back-pressure", irq_vector, 8'h2B);
    ack();
    chk(irq_valid == 1'b0, "R7 valid low after fire", irq_valid, 0);
    expect_quiet(4, "R8 level 0 busy blocks ext0");
  endtask

  initial begin
    t_reset();
    t_regs();
    t_vectors();
    t_mask();
    t_poll();
    t_levels();
    t_ext_modes();
    t_hold();
    summary();
    $finish;
  end
endmodule